// File: doc/BRIEF.md
# Periodic Wakeup and Reset Timer

This block turns a slow, always-running tick (nominally one per millisecond, presented as a one-cycle strobe in the system clock domain) into two periodic events: a wakeup interrupt and a system reset request. The tick passes through four cascaded counting stages. The first stage is a prescaler that trims for error in the tick period. The second is a divider that forms the wakeup clock, meant to be calibrated to roughly one second. The third counts wakeup-clock pulses up to the wakeup interval. The fourth counts wakeup events up to the reset interval.

Two enable inputs choose what the events do. The wakeup event can raise an interrupt, and the reset event can issue a one-cycle reset request. The enable encoding cannot turn both off: when both enables are low, the interrupt is forced on. Once the interrupt is raised, no enable setting can hide it. Only its acknowledge clears it. Each event also sets a status flag that has its own acknowledge input.

Top module: `pwt_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `wake_flag`, `reset_flag`, `irq` and `reset_req` are all low. All stage counters restart from zero, so the first events after reset arrive after a full period.
- R2: The prescaler emits one pulse for every `cfg_prescale`+1 ticks, for any of the 64 values 0 to 63.
- R3: The divider emits one wakeup-clock pulse for every `cfg_divide`+1 prescaler pulses.
- R4: A wakeup event happens on every (`cfg_wake_len`+1)-th wakeup-clock pulse. The counter returns to zero on that same tick, so the event repeats exactly every (P+1)(D+1)(W+1) ticks, where P, D and W are the prescale, divide and wake-length fields.
- R5: A reset event happens on every (`cfg_reset_len`+1)-th wakeup event, that is, every (P+1)(D+1)(W+1)(R+1) ticks, where R is the reset-length field.
- R6: `wake_flag` goes high on the clock edge that samples the tick completing a wakeup event. It stays high until an edge where `wake_ack` is high and no wakeup event occurs. If an event and the acknowledge arrive on the same edge, the flag stays set.
- R7: `reset_flag` behaves the same way for reset events and `reset_ack`. It is set on every reset event, whatever the enables are.
- R8: The interrupt enable in effect is `en_wake` OR NOT `en_reset`. `irq` goes high on a wakeup event while that enable is high. It is cleared by `wake_ack` under the same priority rule as R6.
- R9: Once high, `irq` stays high whatever happens to `en_wake` and `en_reset`, until it is acknowledged.
- R10: `reset_req` is high for exactly one cycle, the cycle after the edge that samples a reset event, and only if `en_reset` is high on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle strobe per slow tick |
| cfg_prescale | input | 6 | Prescaler terminal value (divide by value+1) |
| cfg_divide | input | 6 | Wakeup-clock divider terminal value |
| cfg_wake_len | input | 6 | Wakeup-clock pulses per wakeup event, minus one |
| cfg_reset_len | input | 6 | Wakeup events per reset event, minus one |
| en_wake | input | 1 | Wakeup interrupt enable |
| en_reset | input | 1 | Periodic reset enable |
| wake_ack | input | 1 | Clears wake_flag and irq |
| reset_ack | input | 1 | Clears reset_flag |
| wake_flag | output | 1 | Sticky wakeup event flag |
| reset_flag | output | 1 | Sticky reset event flag |
| irq | output | 1 | Wakeup interrupt |
| reset_req | output | 1 | One-cycle periodic reset request |

## Verification
The bench targets the terminal-value reload. A design that returned to zero one tick late, or counted to the field value rather than to value+1, would drift off the exact period product. It also drives the prescaler and the divider at their largest setting, where an off-by-one or a wrap fault shows up at once. Acknowledges are driven on the same edge as an event, where a design that gave the acknowledge priority would lose the event. Enables are toggled while the interrupt is pending, which exposes any masking of a raised interrupt. The case with both enables low checks that the interrupt is forced on rather than left silent.

// File: rtl/pwt_pkg.sv
`timescale 1ns/1ps
package pwt_pkg;
    localparam int CNT_W   = 6;
    localparam int N_STAGE = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    // stage order is behaviour: each stage steps on the previous stage's hit
    typedef enum logic [1:0] {
        ST_PRE  = 2'd0,
        ST_DIV  = 2'd1,
        ST_WAKE = 2'd2,
        ST_RST  = 2'd3
    } stage_e;

    typedef struct packed {
        cnt_t prescale;
        cnt_t divide;
        cnt_t wake_len;
        cnt_t reset_len;
    } cfg_t;

    typedef struct packed {
        logic wake;
        logic reset;
    } mode_t;

    typedef struct packed {
        logic wake_ev;
        logic reset_ev;
    } event_t;

    // neither-function encoding is folded into wakeup
    function automatic mode_t resolve_mode(logic wake_en, logic reset_en);
        mode_t m;
        m.wake  = wake_en | ~reset_en;
        m.reset = reset_en;
        return m;
    endfunction

    function automatic cnt_t stage_limit(cfg_t c, stage_e s);
        case (s)
            ST_PRE:  return c.prescale;
            ST_DIV:  return c.divide;
            ST_WAKE: return c.wake_len;
            default: return c.reset_len;
        endcase
    endfunction
endpackage

// File: rtl/pwt_stage.sv
`timescale 1ns/1ps
module pwt_stage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = step && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= hit ? '0 : W'(cnt + 1'b1);
    end
endmodule

// File: rtl/pwt_flags.sv
`timescale 1ns/1ps
module pwt_flags
    import pwt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  event_t ev,
    input  mode_t  mode,
    input  logic   wake_ack,
    input  logic   reset_ack,
    output logic   wake_flag,
    output logic   reset_flag,
    output logic   irq,
    output logic   reset_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_flag  <= 1'b0;
            reset_flag <= 1'b0;
            irq        <= 1'b0;
            reset_req  <= 1'b0;
        end else begin
            if (ev.wake_ev)
                wake_flag <= 1'b1;
            else if (wake_ack)
                wake_flag <= 1'b0;

            if (ev.reset_ev)
                reset_flag <= 1'b1;
            else if (reset_ack)
                reset_flag <= 1'b0;

            if (ev.wake_ev && mode.wake)
                irq <= 1'b1;
            else if (wake_ack)
                irq <= 1'b0;

            reset_req <= ev.reset_ev && mode.reset;
        end
    end
endmodule

// File: rtl/pwt_timer.sv
`timescale 1ns/1ps
module pwt_timer
    import pwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lf_tick,
    input  logic [5:0] cfg_prescale,
    input  logic [5:0] cfg_divide,
    input  logic [5:0] cfg_wake_len,
    input  logic [5:0] cfg_reset_len,
    input  logic       en_wake,
    input  logic       en_reset,
    input  logic       wake_ack,
    input  logic       reset_ack,
    output logic       wake_flag,
    output logic       reset_flag,
    output logic       irq,
    output logic       reset_req
);
    cfg_t   cfg;
    mode_t  mode;
    event_t ev;
    logic [N_STAGE:0] step;

    assign cfg.prescale  = cfg_prescale;
    assign cfg.divide    = cfg_divide;
    assign cfg.wake_len  = cfg_wake_len;
    assign cfg.reset_len = cfg_reset_len;
    assign mode          = resolve_mode(en_wake, en_reset);
    assign step[0]       = lf_tick;

    for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
        pwt_stage #(.W(CNT_W)) i_stage (
            .clk   (clk),
            .rst   (rst),
            .step  (step[i]),
            .limit (stage_limit(cfg, stage_e'(i))),
            .hit   (step[i+1])
        );
    end

    assign ev.wake_ev  = step[int'(ST_WAKE) + 1];
    assign ev.reset_ev = step[int'(ST_RST) + 1];

    pwt_flags i_flags (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .mode       (mode),
        .wake_ack   (wake_ack),
        .reset_ack  (reset_ack),
        .wake_flag  (wake_flag),
        .reset_flag (reset_flag),
        .irq        (irq),
        .reset_req  (reset_req)
    );
endmodule

// File: rtl/pwt_checker.sv
`timescale 1ns/1ps
module pwt_checker (
    input logic clk,
    input logic rst,
    input logic lf_tick,
    input logic en_reset,
    input logic wake_ack,
    input logic reset_ack,
    input logic wake_flag,
    input logic reset_flag,
    input logic irq,
    input logic reset_req
);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    p_req_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(en_reset) && $past(lf_tick));

    p_req_sets_wake_r5: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> wake_flag && reset_flag);

    p_irq_no_mask_r9: assert property (@(posedge clk) disable iff (rst)
        irq && !wake_ack |=> irq);

    p_wake_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        wake_flag && !wake_ack |=> wake_flag);

    p_reset_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        reset_flag && !reset_ack |=> reset_flag);

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> wake_flag && $past(lf_tick));

    p_flag_rise_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(lf_tick));
endmodule

bind pwt_timer pwt_checker i_pwt_checker (.*);

// File: tb/test_pwt_timer.sv
`timescale 1ns/1ps
module test_pwt_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lf_tick = 1'b0;
    logic [5:0] cfg_prescale = '0, cfg_divide = '0, cfg_wake_len = '0, cfg_reset_len = '0;
    logic       en_wake = 1'b1, en_reset = 1'b1;
    logic       wake_ack = 1'b0, reset_ack = 1'b0;
    logic       wake_flag, reset_flag, irq, reset_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model
    int  k, pw, rp;
    bit  m_wf, m_rf, m_irq;

    always #2.5 clk = ~clk;

    pwt_timer i_pwt_timer (
        .clk(clk), .rst(rst), .lf_tick(lf_tick),
        .cfg_prescale(cfg_prescale), .cfg_divide(cfg_divide),
        .cfg_wake_len(cfg_wake_len), .cfg_reset_len(cfg_reset_len),
        .en_wake(en_wake), .en_reset(en_reset),
        .wake_ack(wake_ack), .reset_ack(reset_ack),
        .wake_flag(wake_flag), .reset_flag(reset_flag),
        .irq(irq), .reset_req(reset_req)
    );

    function automatic bit is_wake_ev(int n);
        return (n % pw) == 0;
    endfunction

    function automatic bit is_reset_ev(int n);
        return (n % rp) == 0;
    endfunction

    function automatic bit irq_enabled(bit ew, bit er);
        return ew || !er;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (tick %0d)", req, act, exp, k);
        end
    endtask

    task automatic setup(int p, int d, int w, int r, bit ew, bit er);
        @(negedge clk);
        rst = 1'b1;
        lf_tick = 1'b0; wake_ack = 1'b0; reset_ack = 1'b0;
        cfg_prescale = 6'(p); cfg_divide = 6'(d);
        cfg_wake_len = 6'(w); cfg_reset_len = 6'(r);
        en_wake = ew; en_reset = er;
        pw = (p + 1) * (d + 1) * (w + 1);
        rp = pw * (r + 1);
        k = 0; m_wf = 0; m_rf = 0; m_irq = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 wake_flag in reset", wake_flag, 1'b0);
        chk("R1 irq in reset", irq, 1'b0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 reset_flag after reset", reset_flag, 1'b0);
        chk("R1 reset_req after reset", reset_req, 1'b0);
    endtask

    // one tick edge then one idle edge; acks may accompany either
    task automatic tick(string wtag, bit aw, bit ar, bit iaw, bit iar);
        bit wev, rev;
        lf_tick = 1'b1; wake_ack = aw; reset_ack = ar;
        @(posedge clk); @(negedge clk);
        k++;
        wev = is_wake_ev(k);
        rev = is_reset_ev(k);
        m_wf  = wev ? 1'b1 : (aw ? 1'b0 : m_wf);
        m_rf  = rev ? 1'b1 : (ar ? 1'b0 : m_rf);
        m_irq = (wev && irq_enabled(en_wake, en_reset)) ? 1'b1 : (aw ? 1'b0 : m_irq);
        chk(wtag, wake_flag, m_wf);
        chk("R5/R7 reset_flag", reset_flag, m_rf);
        chk("R8 irq", irq, m_irq);
        chk("R10 reset_req", reset_req, rev && en_reset);
        lf_tick = 1'b0; wake_ack = iaw; reset_ack = iar;
        @(posedge clk); @(negedge clk);
        if (iaw) begin m_wf = 0; m_irq = 0; end
        if (iar) m_rf = 0;
        chk("R10 reset_req one cycle", reset_req, 1'b0);
        chk("R6 wake_flag idle", wake_flag, m_wf);
        chk("R7 reset_flag idle", reset_flag, m_rf);
        wake_ack = 1'b0; reset_ack = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        // R2: largest prescale
        setup(63, 0, 0, 1, 1'b1, 1'b1);
        for (int i = 0; i < 130; i++) tick("R2 wake_flag", 1'b0, 1'b0, i % 64 == 5, i % 64 == 9);
        // R3: largest divide
        setup(0, 63, 1, 0, 1'b1, 1'b0);
        for (int i = 0; i < 260; i++) tick("R3 wake_flag", 1'b0, 1'b0, i % 32 == 3, i % 32 == 4);
        // R4 / R5 mixed
        setup(1, 1, 5, 2, 1'b0, 1'b1);
        for (int i = 0; i < 150; i++) tick("R4 wake_flag", 1'b0, 1'b0, i % 7 == 0, i % 11 == 0);
        // R6 / R7: ack on the same edge as an event
        setup(0, 0, 0, 0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) tick("R6 set beats ack", 1'b1, 1'b1, 1'b0, 1'b0);
        // R8: both enables low forces interrupt
        setup(0, 1, 0, 3, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) tick("R8 wake_flag", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 forced irq", irq, 1'b1);
        // R9: no mask once raised
        setup(0, 0, 3, 3, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) tick("R9 wake_flag", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 irq raised", irq, 1'b1);
        en_wake = 1'b0; en_reset = 1'b1;
        tick("R9 wake_flag", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 irq held after enable change", irq, 1'b1);
        tick("R9 wake_flag", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 irq cleared by ack", irq, 1'b0);
        // random configurations
        for (int c = 0; c < 14; c++) begin
            setup($urandom % 3, $urandom % 3, $urandom % 3, $urandom % 3,
                  1'($urandom % 2), 1'($urandom % 2));
            for (int i = 0; i < rp * 2 + 2; i++) begin
                if ($urandom % 8 == 0) begin
                    en_wake = 1'($urandom % 2);
                    en_reset = 1'($urandom % 2);
                end
                tick("R4 wake_flag", 1'($urandom % 5 == 0), 1'($urandom % 5 == 0),
                     1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule